// File: doc/BRIEF.md
# XOR-Enabled Binary Up-Counter

This block is an up-counter of parameterised width (eight bits by default). It behaves like a stage-by-stage ripple counter, but it is built fully synchronous so that it suits a standard-cell flow. Typical uses are dividing one fast clock into several slower ones, or counting events in a time-measurement path.

Counting is gated by two enable inputs that are combined by exclusive-OR. When both are low or both are high, the counter advances on every clock edge. When exactly one of them is high, it freezes and holds its value. The enable pair is sampled at the same edge it governs, so an enable change that arrives together with a clock edge already takes effect at that edge.

A separate start input forces counting whatever the enable pair says. The master reset clears the count at once, without waiting for a clock edge, and it overrides every other input.

Top module: `xgc_counter`

## Requirements
- R1: While `mrst_i` is high, `count_o` is all zeros, and it becomes zero as soon as `mrst_i` rises, without waiting for a clock edge.
- R2: With both `en_a_i` and `en_b_i` low and `mrst_i` low, every rising clock edge adds one to `count_o`.
- R3: With both `en_a_i` and `en_b_i` high and `mrst_i` low, every rising clock edge adds one to `count_o`.
- R4: At a rising edge where exactly one of `en_a_i` and `en_b_i` is high and `astart_i` is low, `count_o` keeps its previous value. This holds at the very edge that first samples that enable pattern.
- R5: With `astart_i` high, every rising edge adds one to `count_o`, even when exactly one enable is high.
- R6: Counting wraps from all ones (8'hFF at the default width) to all zeros, and counting then continues.
- R7: `mrst_i` overrides `astart_i` and both enables: while it is high, no edge changes `count_o` away from zero. After release, the first counting edge gives a count of one.
- R8: After a hold, the first edge that samples an equal enable pair (both high or both low) advances the count again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Counting clock, rising edge |
| mrst_i | input | 1 | Asynchronous master reset, active high |
| astart_i | input | 1 | Start override, active high, forces counting |
| en_a_i | input | 1 | First enable of the XOR pair |
| en_b_i | input | 1 | Second enable of the XOR pair |
| count_o | output | WIDTH | Current count value |

## Verification
Two functions can act in the same cycle: the enable pair changes to a new pattern at the very edge it governs, and the start override or the master reset overrides that pattern. The bench changes the enable pair and the start input just before the edge in many combinations, including single-enable patterns with the start input high. It also raises the master reset in the middle of a cycle while the start input asks for counting. Each result is judged against a behavioural model that decides, per edge, whether the count moves, and the wrap from all ones is provoked by a long free-running stretch.

// File: rtl/xgc_pkg.sv
package xgc_pkg;

   typedef enum logic {
      XGC_ADDER  = 1'b0,
      XGC_TOGGLE = 1'b1
   } xgc_impl_e;

   function automatic logic xgc_run(input logic a, input logic b, input logic start);
      return start | ~(a ^ b);
   endfunction

endpackage

// File: rtl/xgc_enable_gate.sv
module xgc_enable_gate (
   input  logic en_a_i,
   input  logic en_b_i,
   input  logic astart_i,
   output logic run_o
);
   // The pair is evaluated combinationally so the count register captures
   // it at the same edge; the flop stage of the enable is the count flop.
   always_comb run_o = xgc_pkg::xgc_run(en_a_i, en_b_i, astart_i);
endmodule

// File: rtl/xgc_toggle_bit.sv
module xgc_toggle_bit (
   input  logic clk_i,
   input  logic mrst_i,
   input  logic tog_i,
   output logic q_o
);
   always_ff @(posedge clk_i or posedge mrst_i) begin
      if (mrst_i)     q_o <= 1'b0;
      else if (tog_i) q_o <= ~q_o;
   end
endmodule

// File: rtl/xgc_counter.sv
module xgc_counter #(
   parameter int unsigned        WIDTH = 8,
   parameter xgc_pkg::xgc_impl_e IMPL  = xgc_pkg::XGC_TOGGLE
) (
   input  logic             clk_i,
   input  logic             mrst_i,
   input  logic             astart_i,
   input  logic             en_a_i,
   input  logic             en_b_i,
   output logic [WIDTH-1:0] count_o
);
   localparam int unsigned MSB = WIDTH - 1;

   if (WIDTH < 2 || WIDTH > 64) begin : g_bad_width
      $error("xgc_counter: WIDTH must lie in 2..64");
   end

   logic run;

   xgc_enable_gate u_gate (
      .en_a_i   (en_a_i),
      .en_b_i   (en_b_i),
      .astart_i (astart_i),
      .run_o    (run)
   );

   if (IMPL == xgc_pkg::XGC_TOGGLE) begin : g_toggle
      logic [WIDTH:0]   carry;
      logic [MSB:0]     q;
      assign carry[0] = run;
      for (genvar i = 0; i < WIDTH; i++) begin : g_stage
         xgc_toggle_bit u_bit (
            .clk_i  (clk_i),
            .mrst_i (mrst_i),
            .tog_i  (carry[i]),
            .q_o    (q[i])
         );
         assign carry[i+1] = carry[i] & q[i];
      end
      assign count_o = q;
   end else begin : g_adder
      logic [MSB:0] q;
      always_ff @(posedge clk_i or posedge mrst_i) begin
         if (mrst_i)   q <= '0;
         else if (run) q <= q + 1'b1;
      end
      assign count_o = q;
   end
endmodule

// File: rtl/xgc_counter_chk.sv
module xgc_counter_chk #(
   parameter int unsigned WIDTH = 8
) (
   input logic             clk_i,
   input logic             mrst_i,
   input logic             astart_i,
   input logic             en_a_i,
   input logic             en_b_i,
   input logic [WIDTH-1:0] count_o
);
   always @(negedge clk_i) begin
      if (mrst_i) begin
         assert_reset_zero_R1: assert (count_o == '0);
      end
   end

   assert_equal_pair_counts_R2: assert property (@(posedge clk_i) disable iff (mrst_i)
      (!astart_i && en_a_i == en_b_i) |=> count_o == WIDTH'($past(count_o) + 1'b1));

   assert_single_enable_holds_R4: assert property (@(posedge clk_i) disable iff (mrst_i)
      (!astart_i && en_a_i != en_b_i) |=> $stable(count_o));

   assert_start_overrides_R5: assert property (@(posedge clk_i) disable iff (mrst_i)
      astart_i |=> count_o == WIDTH'($past(count_o) + 1'b1));

   assert_wrap_to_zero_R6: assert property (@(posedge clk_i) disable iff (mrst_i)
      (count_o == '1 && (astart_i || en_a_i == en_b_i)) |=> count_o == '0);
endmodule

bind xgc_counter xgc_counter_chk #(.WIDTH(WIDTH)) u_chk (
   .clk_i    (clk_i),
   .mrst_i   (mrst_i),
   .astart_i (astart_i),
   .en_a_i   (en_a_i),
   .en_b_i   (en_b_i),
   .count_o  (count_o)
);

// File: tb/xgc_counter_tb.sv
module xgc_counter_tb;
   localparam int CLK_PERIOD = 10;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         mrst = 1'b1;
   logic         astart = 1'b0;
   logic         en_a = 1'b0;
   logic         en_b = 1'b0;
   logic [W-1:0] count;

   int compared = 0;
   int mismatched = 0;
   int model = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   xgc_counter #(.WIDTH(W)) u_dut (
      .clk_i    (clk),
      .mrst_i   (mrst),
      .astart_i (astart),
      .en_a_i   (en_a),
      .en_b_i   (en_b),
      .count_o  (count)
   );

   task automatic check(input string tag);
      compared++;
      if (count !== W'(model)) begin
         mismatched++;
         $display("FAIL %s: count=%0h expected=%0h", tag, count, W'(model));
      end
   endtask

   // Called just after a falling edge: drive, take one rising edge, compare.
   task automatic step(input logic a, input logic b, input logic s, input string tag);
      en_a = a; en_b = b; astart = s;
      @(posedge clk);
      if (mrst) model = 0;
      else if (s || (a == b)) model = (model + 1) % (1 << W);
      @(negedge clk);
      check(tag);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      model = 0;
      check("R1");
      mrst = 1'b0;

      for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 1'b0, "R2");
      for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b0, "R3");
      for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, "R4");
      for (int i = 0; i < 2; i++) step(1'b0, 1'b1, 1'b0, "R4");
      step(1'b1, 1'b1, 1'b0, "R8");
      step(1'b0, 1'b1, 1'b0, "R4");
      step(1'b0, 1'b0, 1'b0, "R8");
      for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b1, "R5");
      step(1'b0, 1'b1, 1'b1, "R5");

      // long free run across the all-ones boundary
      for (int i = 0; i < 260; i++) step(1'b0, 1'b0, 1'b0, "R6");
      // park on all ones, then wrap with a start override on a single enable
      while (count != '1) step(1'b0, 1'b0, 1'b0, "R6");
      step(1'b1, 1'b0, 1'b1, "R6");

      // mixed patterns
      for (int i = 0; i < 40; i++) begin
         logic a = i[0];
         logic b = i[1] ^ i[3];
         logic s = (i % 7) == 3;
         step(a, b, s, s ? "R5" : ((a != b) ? "R4" : "R2"));
      end

      // asynchronous reset mid-cycle while counting is requested
      step(1'b0, 1'b0, 1'b0, "R2");
      astart = 1'b1; en_a = 1'b1; en_b = 1'b1;
      #2 mrst = 1'b1;
      #1;
      model = 0;
      check("R1");
      for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1, "R7");
      mrst = 1'b0;
      step(1'b0, 1'b0, 1'b1, "R7");
      step(1'b0, 1'b1, 1'b0, "R4");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule